// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer with Early Termination

This block is the digital control core of a 16-bit successive-approximation converter. A conversion request arrives as a pulse on `conv_req`; its trailing (falling) edge starts a conversion. The block raises `busy`, releases a gated bit clock to the pins, and walks a trial word from the most significant bit down. At each step it keeps or drops the previous trial bit according to the single comparator bit `cmp_in`, then puts the next bit on trial. The feedback converter and the analog comparator sit outside. They are represented by the `trial` word driven out and the `cmp_in` bit returned (`cmp_in` = 1 means the analog input is at or above the level of the current trial word, so the bit is kept).

Results leave in two forms, both negative-true. `par_out` is a parallel word and `ser_out` is an NRZ serial stream, MSB first, that a receiver clocks in on falling bit-clock edges. A short-cycle length ends the conversion after fewer bit decisions. An external pacing mode lets each falling edge of `conv_req` advance the sequence by one step, instead of the internal clock.

The controller has four states:
- `ST_IDLE`: waiting for a start.
- `ST_HI`: bit clock high; the step action happens on entry.
- `ST_LO`: bit clock low.
- `ST_WAIT`: external mode only; waiting for the next pacing edge.

It has six transitions:
- start: `ST_IDLE`→`ST_HI` on a falling request edge.
- half: `ST_HI`→`ST_LO`, always taken.
- next: `ST_LO`→`ST_HI` in internal mode while steps remain.
- park: `ST_LO`→`ST_WAIT` in external mode while steps remain.
- pace: `ST_WAIT`→`ST_HI` on a falling request edge.
- finish: `ST_LO`→`ST_IDLE` after the last decision.

Top module: `sar_seq_ctrl`

## Requirements
- R1: While the synchronous active-high `rst` is high, and at the first clock after it, `busy` and `bit_clk` are 0, `trial` is all zeros, `par_out` is all ones and `ser_out` is 0.
- R2: A falling edge of `conv_req` is seen at the first rising `clk` edge that samples it low after it was sampled high. When the block is idle, `busy` goes to 1 at that edge and stays 1 until the conversion ends. `busy` falls two `clk` cycles after the last bit-clock rise, and `bit_clk` is low in the cycle before and in the cycle of that fall.
- R3: `bit_clk` is 0 whenever `busy` is 0. Each step drives `bit_clk` high for one `clk` cycle and then low for one. In internal mode the steps follow back to back, giving N+1 pulses for a length of N.
- R4: At step 0, `trial` becomes the MSB alone (bit RES-1 = 1, all others 0). At step k (1..N), bit RES-k takes the value of `cmp_in` sampled at that edge, and bit RES-1-k is set to 1 when k < N. `trial` changes only at a rising edge of `bit_clk`.
- R5: `short_len` is sampled at the start edge. The values 8, 10, 12, 13, 14, 15 and 16 select that many decisions; any other value selects 16. Bits below the chosen length stay 0 in `trial`, and therefore 1 in `par_out`.
- R6: `par_out` is the bitwise complement of `trial`. With `CODING` = `CODE_CTC`, bit 15 is inverted once more. With `CODE_CSB` or `CODE_COB`, the bit pattern is the plain complement.
- R7: At step k ≥ 1, `ser_out` becomes the complement of decision k, with the MSB decision also inverted under `CODE_CTC`. Step 0 leaves `ser_out` unchanged. A receiver that shifts `ser_out` in on every falling `bit_clk` edge holds, in its low N bits, the top N bits of `par_out`.
- R8: Falling edges of `conv_req` while `busy` is 1 have no effect on the sequence or on the result.
- R9: If `ext_pace` is 1 at the start edge, the first falling edge of `conv_req` performs step 0. Each later falling edge seen in `ST_WAIT` performs one further step. `busy` falls two cycles after the edge that performs step N, so N+1 request pulses make one conversion.
- R10: While the block is idle, `par_out` and `ser_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_req | input | 1 | Conversion request; its falling edge starts a conversion or, in paced mode, advances it by one step |
| ext_pace | input | 1 | 1 at the start edge selects external pacing by `conv_req` |
| short_len | input | 5 | Requested number of bit decisions |
| cmp_in | input | 1 | Comparator result for the current trial word (1 = keep) |
| busy | output | 1 | Conversion in progress |
| bit_clk | output | 1 | Gated bit clock, low when idle |
| trial | output | 16 | Trial word for the feedback converter, true sense |
| par_out | output | 16 | Parallel result, complementary coding |
| ser_out | output | 1 | Serial result, NRZ, MSB first, complementary |

## Verification
A wrong state or step count shows at the ports within one or two `clk` cycles. It appears as a missing or extra `bit_clk` pulse, or as `busy` falling at the wrong edge. A wrong decision index shows at the next bit-clock rise as a wrong bit in `trial` and `par_out`, and as a wrong serial bit one falling edge later. The bench therefore compares `busy`, `bit_clk`, `par_out` and `ser_out` against a behavioural model on every clock. It does this across internal and paced conversions, every legal and one illegal length, and starts issued during a conversion. It also checks the serial word assembled at the receiver.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HI,
        ST_LO,
        ST_WAIT
    } seq_state_e;

    typedef enum logic [1:0] {
        CODE_CSB,
        CODE_COB,
        CODE_CTC
    } code_mode_e;

    // Accepted early-termination lengths; anything else runs the full width.
    function automatic int pick_len(input int res, input int req);
        if (req > 0 && (req == res || req == res - 1 || req == res - 2 ||
                        req == res - 3 || req == res - 4 || req == res - 6 ||
                        req == res - 8))
            return req;
        return res;
    endfunction

endpackage

// File: rtl/sar_edge_det.sv
module sar_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic fall
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= din;
    end

    assign fall = prev_q & ~din;

endmodule

// File: rtl/sar_fsm.sv
module sar_fsm
    import sar_seq_pkg::*;
#(
    parameter int RES   = 16,
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_fall,
    input  logic             ext_pace,
    input  logic [LEN_W-1:0] short_len,
    output logic             go,
    output logic [LEN_W-1:0] go_idx,
    output logic [LEN_W-1:0] len_q,
    output logic             busy,
    output logic             bit_clk
);

    seq_state_e       state_q, state_nx;
    logic [LEN_W-1:0] stp_q;
    logic             ext_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (start_fall) state_nx = ST_HI;
            ST_HI:   state_nx = ST_LO;
            ST_LO: begin
                if (stp_q == len_q) state_nx = ST_IDLE;
                else if (ext_q)     state_nx = ST_WAIT;
                else                state_nx = ST_HI;
            end
            ST_WAIT: if (start_fall) state_nx = ST_HI;
            default: state_nx = ST_IDLE;
        endcase
    end

    assign go     = (state_nx == ST_HI);
    assign go_idx = (state_q == ST_IDLE) ? '0 : stp_q + LEN_W'(1);

    // step counter and settings latched at the start edge
    always_ff @(posedge clk) begin
        if (rst) begin
            stp_q <= '0;
            len_q <= LEN_W'(RES);
            ext_q <= 1'b0;
        end else begin
            if (go) stp_q <= go_idx;
            if (state_q == ST_IDLE && start_fall) begin
                len_q <= LEN_W'(pick_len(RES, int'(short_len)));
                ext_q <= ext_pace;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            bit_clk <= 1'b0;
        end else begin
            busy    <= (state_nx != ST_IDLE);
            bit_clk <= (state_nx == ST_HI);
        end
    end

endmodule

// File: rtl/sar_datapath.sv
module sar_datapath #(
    parameter int RES      = 16,
    parameter int LEN_W    = 5,
    parameter bit FLIP_MSB = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [LEN_W-1:0] go_idx,
    input  logic [LEN_W-1:0] len_q,
    input  logic             cmp_in,
    output logic [RES-1:0]   sar_q,
    output logic             ser_q
);

    logic [RES-1:0] sar_nx;

    always_comb begin
        sar_nx = sar_q;
        if (go_idx == '0) begin
            sar_nx          = '0;
            sar_nx[RES-1]   = 1'b1;
        end else begin
            for (int i = 0; i < RES; i++) begin
                if (i == RES - int'(go_idx))
                    sar_nx[i] = cmp_in;
                else if (i == RES - 1 - int'(go_idx) && go_idx < len_q)
                    sar_nx[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sar_q <= '0;
            ser_q <= 1'b0;
        end else if (go) begin
            sar_q <= sar_nx;
            if (go_idx != '0)
                ser_q <= ~cmp_in ^ (FLIP_MSB && go_idx == LEN_W'(1));
        end
    end

endmodule

// File: rtl/sar_out_code.sv
module sar_out_code
    import sar_seq_pkg::*;
#(
    parameter int         RES    = 16,
    parameter code_mode_e CODING = CODE_CSB
) (
    input  logic [RES-1:0] sar_q,
    output logic [RES-1:0] par_out
);

    generate
        if (CODING == CODE_CTC) begin : g_ctc
            assign par_out = {sar_q[RES-1], ~sar_q[RES-2:0]};
        end else begin : g_plain
            assign par_out = ~sar_q;
        end
    endgenerate

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int         RES    = 16,
    parameter code_mode_e CODING = CODE_CSB,
    localparam int        LEN_W  = $clog2(RES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_req,
    input  logic             ext_pace,
    input  logic [LEN_W-1:0] short_len,
    input  logic             cmp_in,
    output logic             busy,
    output logic             bit_clk,
    output logic [RES-1:0]   trial,
    output logic [RES-1:0]   par_out,
    output logic             ser_out
);

    localparam bit FLIP_MSB = (CODING == CODE_CTC);

    logic             start_fall;
    logic             go;
    logic [LEN_W-1:0] go_idx;
    logic [LEN_W-1:0] len_q;

    sar_edge_det u_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (conv_req),
        .fall (start_fall)
    );

    sar_fsm #(.RES(RES), .LEN_W(LEN_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start_fall (start_fall),
        .ext_pace   (ext_pace),
        .short_len  (short_len),
        .go         (go),
        .go_idx     (go_idx),
        .len_q      (len_q),
        .busy       (busy),
        .bit_clk    (bit_clk)
    );

    sar_datapath #(.RES(RES), .LEN_W(LEN_W), .FLIP_MSB(FLIP_MSB)) u_dp (
        .clk    (clk),
        .rst    (rst),
        .go     (go),
        .go_idx (go_idx),
        .len_q  (len_q),
        .cmp_in (cmp_in),
        .sar_q  (trial),
        .ser_q  (ser_out)
    );

    sar_out_code #(.RES(RES), .CODING(CODING)) u_code (
        .sar_q   (trial),
        .par_out (par_out)
    );

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int RES = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           busy,
    input logic           bit_clk,
    input logic [RES-1:0] trial,
    input logic [RES-1:0] par_out,
    input logic           ser_out
);

    assert_clk_gated_R3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bit_clk);

    assert_first_trial_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (trial == {1'b1, {(RES-1){1'b0}}}));

    assert_trial_on_rise_R4: assert property (@(posedge clk) disable iff (rst)
        !$rose(bit_clk) |-> $stable(trial));

    assert_busy_end_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (!bit_clk && $past(!bit_clk)));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy)) |-> ($stable(par_out) && $stable(ser_out)));

endmodule

bind sar_seq_ctrl sar_seq_chk #(.RES(RES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .bit_clk (bit_clk),
    .trial   (trial),
    .par_out (par_out),
    .ser_out (ser_out)
);

// File: tb/sar_seq_ctrl_bench.sv
module sar_seq_ctrl_bench;
    import sar_seq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_req = 1'b0;
    logic        ext_pace = 1'b0;
    logic [4:0]  short_len = 5'd16;
    logic [15:0] vin = 16'h0;
    logic        cmp_in;
    logic        busy, bit_clk, ser_out;
    logic [15:0] trial, par_out;
    logic        busy_c, bit_clk_c, ser_c;
    logic [15:0] trial_c, par_c;
    logic        cmp_c;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign cmp_in = (vin >= trial);
    assign cmp_c  = (vin >= trial_c);

    sar_seq_ctrl u_sar_seq_ctrl (
        .clk(clk), .rst(rst), .conv_req(conv_req), .ext_pace(ext_pace),
        .short_len(short_len), .cmp_in(cmp_in), .busy(busy), .bit_clk(bit_clk),
        .trial(trial), .par_out(par_out), .ser_out(ser_out)
    );

    sar_seq_ctrl #(.CODING(CODE_CTC)) u_sar_seq_ctrl_ctc (
        .clk(clk), .rst(rst), .conv_req(conv_req), .ext_pace(ext_pace),
        .short_len(short_len), .cmp_in(cmp_c), .busy(busy_c), .bit_clk(bit_clk_c),
        .trial(trial_c), .par_out(par_c), .ser_out(ser_c)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int len_of(input int req);
        case (req)
            8, 10, 12, 13, 14, 15, 16: return req;
            default:                   return 16;
        endcase
    endfunction

    // behavioural reference: phase 0 idle, 1 clock high, 2 clock low, 3 waiting for pace
    int          m_phase, m_k, m_len;
    bit          m_ext, m_prev, m_busy, m_clk, m_ser, m_keep;
    logic [15:0] m_sar;

    task automatic m_step();
        m_k++;
        m_keep = (vin >= m_sar);
        m_sar[16 - m_k] = m_keep;
        if (m_k < m_len) m_sar[15 - m_k] = 1'b1;
        m_ser   = !m_keep;
        m_clk   = 1'b1;
        m_phase = 1;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_busy = 0; m_clk = 0; m_sar = '0; m_ser = 0; m_prev = 0;
            m_k = 0; m_len = 16; m_ext = 0;
        end else begin
            bit fall;
            fall   = m_prev && !conv_req;
            m_prev = conv_req;
            case (m_phase)
                0: if (fall) begin
                    m_len = len_of(int'(short_len)); m_ext = ext_pace; m_k = 0;
                    m_busy = 1; m_clk = 1; m_sar = 16'h8000; m_phase = 1;
                end
                1: begin m_clk = 0; m_phase = 2; end
                2: begin
                    if (m_k == m_len) begin m_busy = 0; m_phase = 0; end
                    else if (m_ext) m_phase = 3;
                    else m_step();
                end
                default: if (fall) m_step();
            endcase
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            chk(busy == m_busy, "R2 busy", 32'(busy), 32'(m_busy));
            chk(bit_clk == m_clk, "R3 bit_clk", 32'(bit_clk), 32'(m_clk));
            chk(par_out == ~m_sar, "R4 par_out", 32'(par_out), 32'(~m_sar));
            chk(ser_out == m_ser, "R7 ser_out", 32'(ser_out), 32'(m_ser));
            chk(par_c == (par_out ^ 16'h8000), "R6 ctc par_out", 32'(par_c),
                32'(par_out ^ 16'h8000));
        end
    end

    logic [15:0] rx = '0;
    always @(negedge bit_clk) rx = {rx[14:0], ser_out};

    task automatic final_checks(input logic [15:0] v, input int len, input string req);
        logic [15:0] mask, code, got, want;
        mask = 16'hFFFF << (16 - len);
        code = v & mask;
        chk(par_out == ~code, req, 32'(par_out), 32'(~code));
        chk(!busy && !bit_clk, "R2 idle after end", 32'({busy, bit_clk}), 32'h0);
        got  = rx & (16'hFFFF >> (16 - len));
        want = (~code) >> (16 - len);
        chk(got == want, "R7 serial receiver", 32'(got), 32'(want));
    endtask

    task automatic conv_int(input logic [15:0] v, input int lreq, input bit poke,
                            input string req);
        int len;
        len = len_of(lreq);
        vin = v; short_len = 5'(lreq); ext_pace = 1'b0; rx = '0;
        conv_req = 1'b1;
        repeat (2) @(negedge clk);
        conv_req = 1'b0;
        @(negedge clk);
        if (poke) begin
            repeat (4) @(negedge clk);
            conv_req = 1'b1; short_len = 5'd8;
            repeat (2) @(negedge clk);
            conv_req = 1'b0;
        end
        repeat (2 * len + 8) @(negedge clk);
        final_checks(v, len, req);
        repeat (3) @(negedge clk);
        chk(!busy, "R10 idle hold", 32'(busy), 32'h0);
    endtask

    task automatic conv_ext(input logic [15:0] v, input int lreq, input string req);
        int len;
        len = len_of(lreq);
        vin = v; short_len = 5'(lreq); ext_pace = 1'b1; rx = '0;
        conv_req = 1'b1;
        repeat (2) @(negedge clk);
        for (int p = 0; p <= len; p++) begin
            conv_req = 1'b0;
            @(negedge clk);
            conv_req = 1'b1;
            if (p == 0) chk(busy, "R9 busy after first pulse", 32'(busy), 32'h1);
            if (p == len - 1) begin
                repeat (3) @(negedge clk);
                chk(busy, "R9 busy before last pulse", 32'(busy), 32'h1);
            end else begin
                repeat (3) @(negedge clk);
            end
        end
        ext_pace = 1'b0;
        repeat (2) @(negedge clk);
        final_checks(v, len, req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !bit_clk && trial == 16'h0 && par_out == 16'hFFFF && !ser_out,
            "R1 reset state", 32'({busy, bit_clk, ser_out, par_out}), 32'hFFFF);
        rst = 1'b0;
        @(negedge clk);
        chk(par_out == 16'hFFFF && !busy, "R1 after reset", 32'(par_out), 32'hFFFF);
        conv_int(16'hA5C3, 16, 1'b0, "R4 full A5C3");
        conv_int(16'h0000, 16, 1'b0, "R4 zero input");
        conv_int(16'hFFFF, 16, 1'b0, "R4 full-scale input");
        conv_int(16'h8421, 12, 1'b0, "R5 len 12");
        conv_int(16'h3CF0, 8,  1'b0, "R5 len 8");
        conv_int(16'h7E81, 10, 1'b0, "R5 len 10");
        conv_int(16'h1234, 13, 1'b0, "R5 len 13");
        conv_int(16'hFEDC, 14, 1'b0, "R5 len 14");
        conv_int(16'h5555, 15, 1'b0, "R5 len 15");
        conv_int(16'h9ABD, 9,  1'b0, "R5 illegal len 9 gives 16");
        conv_int(16'h6B2D, 16, 1'b1, "R8 start during busy ignored");
        conv_ext(16'hC381, 16, "R9 paced full");
        conv_ext(16'h4F0F, 8,  "R9 paced len 8");
        conv_int(16'h0F1E, 16, 1'b0, "R3 internal after paced");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule